// File: doc/BRIEF.md
# Cascaded Low-Power Multi-Counter Timer

This block is a slow-clock timer built from three counters. Two 16-bit match counters (C0, C1) can be chained so that every match event of C0 advances C1 one clock later, which gives a 32-bit span from two 16-bit halves. A third counter, C2, is a free-running 32-bit count that flags an event whenever one chosen bit of it changes state, in either direction. A timer driver arms a wake-up either with a compare on the chained pair or with a power-of-two interval on C2.

Software reaches the block through a flat register port. Writes land on a clock edge. Reads are combinational from a read address. Match and bit-select writes pass through a staging register before they take effect. Counter reset requests complete after a fixed three-cycle delay. A lock bit freezes the configuration registers. Each counter owns one sticky status bit, and each status bit has its own mask bit. The interrupt output is the OR of the unmasked status bits.

Register addresses: 0 control, 1 match (C0 in bits 15:0, C1 in bits 31:16), 2 toggle-bit select (bits 4:0), 3 reset request (bits 2:0 for C0, C1, C2), 4 status, 5 mask, 6 lock (bit 0), 7 pair count, 8 C2 count. The control bits are:
- bits 2:0: enable for C0, C1 and C2
- bit 4: cascade
- bit 5: clear-on-match for C0
- bit 6: clear-on-match for C1

Top module: `mt_lp_timer`

## Requirements
- R1: After reset all counts, the status and the mask read 0, control, lock and toggle select read 0, both match fields read 0xFFFF, and `irq` is low.
- R2: An enabled counter advances by one on each clock edge. A disabled counter holds its value, and enabling it again resumes from that value. A control write only affects the edges after the one that captures it.
- R3: C0 raises status bit 0 on the edge where it steps onto its match value. It then keeps counting, unless its clear-on-match bit (control bit 5) is set. In that case it takes 0 on that edge and so counts modulo the match value.
- R4: With cascade set (control bit 4), C1 steps once per C0 match event, one edge after that event. With cascade clear, C1 steps on every edge while enabled.
- R5: C1 raises status bit 1 when it steps onto its match value. With clear-on-match (control bit 6) it takes 0 on that edge. Otherwise it keeps counting past the match value.
- R6: C2 raises status bit 2 on every step that changes its selected bit, whether 0 to 1 or 1 to 0.
- R7: A match or toggle-select write is first used for comparison on the second edge after the edge that captures it.
- R8: A reset request for a counter (register 3, bit per counter) sets that counter to 0 on the third edge after the write edge.
- R9: Status bits are sticky and are cleared by writing 1 to them at address 4. A new event in the same cycle as a clear wins.
- R10: `irq` is high exactly when some status bit is set together with its mask bit.
- R11: While lock is set, writes to control, match and toggle select are ignored. Writes to status clear, mask, reset request and lock still act.
- R12: Address 7 returns C1 in the upper half and C0 in the lower half, both from the same cycle. Address 8 returns C2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read register address |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench goes after the off-by-one cases:
- A match written one cycle too late to be seen: a design with a single-stage update would fire on it.
- The one-edge queue between a C0 match and the C1 step: a design without the queue steps C1 on the same edge as the match.
- The falling transition of the C2 selected bit: a design that only watches rising edges stays silent on it.
- The third-edge completion of a reset request.

Locked writes are read back, to catch designs that honour them. Clear-on-match counts are compared against modulo arithmetic at random stopping points, which exposes a design that wraps one step early or late.

// File: rtl/mt_pkg.sv
// Shared constants and register address map of the cascaded low-power timer.
// Assumes a single slow clock domain for every register in the block.
package mt_pkg;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 32;
    localparam int NUM_CNT   = 3;
    localparam int RST_DELAY = 3;
    localparam int RST_CW    = $clog2(RST_DELAY + 1);
    localparam int CTRL_W    = 7;
    localparam int CB_CASC   = 4;
    localparam int CB_CLR0   = 5;
    localparam int CB_CLR1   = 6;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 4'd0,
        A_MATCH  = 4'd1,
        A_TOGGLE = 4'd2,
        A_RESET  = 4'd3,
        A_STATUS = 4'd4,
        A_MASK   = 4'd5,
        A_LOCK   = 4'd6,
        A_CNT01  = 4'd7,
        A_CNT2   = 4'd8
    } reg_addr_e;
endpackage

// File: rtl/mt_match_counter.sv
// Match counter with staged match register, clear-on-match and a delayed
// reset request. Assumes 'step' already includes the enable and the
// cascade source; 'hit' is combinational and is valid before the edge.
module mt_match_counter
    import mt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          clr_on_match,
    input  logic          match_wr,
    input  logic [CW-1:0] match_din,
    input  logic          rst_req,
    output logic [CW-1:0] count,
    output logic [CW-1:0] match,
    output logic          hit
);
    logic [CW-1:0]     stage_q;
    logic              stage_vld;
    logic [RST_CW-1:0] rst_cnt;
    logic [CW-1:0]     nxt;
    logic              rst_fire;

    assign nxt      = count + 1'b1;
    assign rst_fire = (rst_cnt == RST_CW'(1));
    assign hit      = step && !rst_fire && (nxt == match);

    // Two-step match update: capture into staging, then move into the active register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q   <= '1;
            stage_vld <= 1'b0;
            match     <= '1;
        end else begin
            stage_vld <= match_wr;
            if (match_wr) stage_q <= match_din;
            if (stage_vld) match <= stage_q;
        end
    end

    // Reset-request countdown; the counter clears when it reaches one.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rst_cnt <= '0;
        else if (rst_req)            rst_cnt <= RST_CW'(RST_DELAY);
        else if (rst_cnt != '0)      rst_cnt <= rst_cnt - 1'b1;
    end

    // Count register: delayed clear, then step with optional wrap on match.
    always_ff @(posedge clk) begin
        if (!rst_n)        count <= '0;
        else if (rst_fire) count <= '0;
        else if (step)     count <= (hit && clr_on_match) ? '0 : nxt;
    end

    // R8
    rst_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_fire |=> (count == '0));
    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !rst_fire) |=> $stable(count));
    // R7
    stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stage_vld |=> (match == $past(stage_q)));
endmodule

// File: rtl/mt_toggle_counter.sv
// Free-running counter that flags each change of one selected bit.
// Assumes the bit select is staged like a match write (two-edge latency).
module mt_toggle_counter
    import mt_pkg::*;
#(
    parameter int C2W = 32,
    parameter int SW  = $clog2(C2W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    input  logic           sel_wr,
    input  logic [SW-1:0]  sel_din,
    input  logic           rst_req,
    output logic [C2W-1:0] count,
    output logic [SW-1:0]  sel,
    output logic           hit
);
    logic [SW-1:0]     stage_q;
    logic              stage_vld;
    logic [RST_CW-1:0] rst_cnt;
    logic [C2W-1:0]    nxt;
    logic              rst_fire;

    assign nxt      = count + 1'b1;
    assign rst_fire = (rst_cnt == RST_CW'(1));
    assign hit      = step && !rst_fire && (nxt[sel] != count[sel]);

    // Two-step bit-select update through a staging register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q   <= '0;
            stage_vld <= 1'b0;
            sel       <= '0;
        end else begin
            stage_vld <= sel_wr;
            if (sel_wr) stage_q <= sel_din;
            if (stage_vld) sel <= stage_q;
        end
    end

    // Reset-request countdown.
    always_ff @(posedge clk) begin
        if (!rst_n)             rst_cnt <= '0;
        else if (rst_req)       rst_cnt <= RST_CW'(RST_DELAY);
        else if (rst_cnt != '0) rst_cnt <= rst_cnt - 1'b1;
    end

    // Free-running count with delayed clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        count <= '0;
        else if (rst_fire) count <= '0;
        else if (step)     count <= nxt;
    end

    // R6
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !rst_fire) |=> (count == $past(count) + 1'b1));
    // R8
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_fire |=> (count == '0));
endmodule

// File: rtl/mt_irq_ctrl.sv
// Sticky per-counter status with write-one-to-clear and per-bit mask.
// Assumes events are single-cycle pulses sampled on the clock edge.
module mt_irq_ctrl #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr_wr,
    input  logic [N-1:0] clr_bits,
    input  logic         mask_wr,
    input  logic [N-1:0] mask_bits,
    output logic [N-1:0] status,
    output logic [N-1:0] mask,
    output logic         irq
);
    // Status: new events win over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~(clr_wr ? clr_bits : '0)) | evt;
    end

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_wr) mask <= mask_bits;
    end

    assign irq = |(status & mask);

    // R9
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((status & $past(evt)) == $past(evt)));
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_wr && evt == '0) |=> $stable(status));
    // R10
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> !irq);
endmodule

// File: rtl/mt_lp_timer.sv
// Top of the cascaded low-power timer: register decode, lock, cascade
// queue and readback. Assumes all inputs are synchronous to the slow clock.
module mt_lp_timer
    import mt_pkg::*;
#(
    parameter int CW  = 16,
    parameter int C2W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam int SW = $clog2(C2W);

    logic [CTRL_W-1:0]  ctrl_q;
    logic               lock_q;
    logic               casc_q;
    logic [1:0]         step;
    logic [1:0]         clr_on;
    logic [CW-1:0]      cnt   [2];
    logic [CW-1:0]      mval  [2];
    logic [NUM_CNT-1:0] hit;
    logic [NUM_CNT-1:0] rst_req;
    logic [NUM_CNT-1:0] status, mask;
    logic [C2W-1:0]     cnt2;
    logic [SW-1:0]      sel;
    logic               wr_ctrl, wr_match, wr_tog, wr_rst;

    assign wr_ctrl  = wr_en && (wr_addr == A_CTRL)   && !lock_q;
    assign wr_match = wr_en && (wr_addr == A_MATCH)  && !lock_q;
    assign wr_tog   = wr_en && (wr_addr == A_TOGGLE) && !lock_q;
    assign wr_rst   = wr_en && (wr_addr == A_RESET);
    assign rst_req  = wr_rst ? wr_data[NUM_CNT-1:0] : '0;

    // Control and lock registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            lock_q <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= wr_data[CTRL_W-1:0];
            if (wr_en && wr_addr == A_LOCK) lock_q <= wr_data[0];
        end
    end

    // Cascade queue: a C0 match steps C1 one edge later.
    always_ff @(posedge clk) begin
        if (!rst_n) casc_q <= 1'b0;
        else        casc_q <= hit[0];
    end

    assign step[0]   = ctrl_q[0];
    assign step[1]   = ctrl_q[1] && (ctrl_q[CB_CASC] ? casc_q : 1'b1);
    assign clr_on[0] = ctrl_q[CB_CLR0];
    assign clr_on[1] = ctrl_q[CB_CLR1];

    for (genvar i = 0; i < 2; i++) begin : g_mcnt
        mt_match_counter #(.CW(CW)) u_cnt (
            .clk          (clk),
            .rst_n        (rst_n),
            .step         (step[i]),
            .clr_on_match (clr_on[i]),
            .match_wr     (wr_match),
            .match_din    (wr_data[i*CW +: CW]),
            .rst_req      (rst_req[i]),
            .count        (cnt[i]),
            .match        (mval[i]),
            .hit          (hit[i])
        );
    end

    mt_toggle_counter #(.C2W(C2W), .SW(SW)) u_tcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (ctrl_q[2]),
        .sel_wr  (wr_tog),
        .sel_din (wr_data[SW-1:0]),
        .rst_req (rst_req[2]),
        .count   (cnt2),
        .sel     (sel),
        .hit     (hit[2])
    );

    mt_irq_ctrl #(.N(NUM_CNT)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (hit),
        .clr_wr    (wr_en && wr_addr == A_STATUS),
        .clr_bits  (wr_data[NUM_CNT-1:0]),
        .mask_wr   (wr_en && wr_addr == A_MASK),
        .mask_bits (wr_data[NUM_CNT-1:0]),
        .status    (status),
        .mask      (mask),
        .irq       (irq)
    );

    // Combinational readback; the counter pair comes from one cycle.
    always_comb begin
        case (rd_addr)
            A_CTRL:   rd_data = DATA_W'(ctrl_q);
            A_MATCH:  rd_data = DATA_W'({mval[1], mval[0]});
            A_TOGGLE: rd_data = DATA_W'(sel);
            A_STATUS: rd_data = DATA_W'(status);
            A_MASK:   rd_data = DATA_W'(mask);
            A_LOCK:   rd_data = DATA_W'(lock_q);
            A_CNT01:  rd_data = DATA_W'({cnt[1], cnt[0]});
            A_CNT2:   rd_data = DATA_W'(cnt2);
            default:  rd_data = '0;
        endcase
    end

    // R11
    lock_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && wr_en && wr_addr == A_CTRL) |=> $stable(ctrl_q));
    // R4
    casc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CB_CASC] && !casc_q && rst_req[1] == 1'b0 && !$past(rst_req[1]) && cnt[1] != '0)
        |=> ($stable(cnt[1]) || cnt[1] == '0));
endmodule

// File: tb/sim_mt_lp_timer.sv
// Self-checking bench: directed corner cases plus seeded random runs.
module sim_mt_lp_timer;
    import mt_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;
    int nchk = 0;
    int nfail = 0;

    mt_lp_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        tick(2);
        rst_n = 1'b1;
    endtask

    function automatic logic [31:0] exp_mod(input int k, input int m);
        return 32'(k % m);
    endfunction

    task automatic run_lat(input int target, input logic exp_hit);
        logic [31:0] v;
        do_reset();
        wr(A_CTRL, 32'h1);
        tick(3);
        wr(A_MATCH, {16'hFFFF, 16'(target)});
        tick(6);
        rd(A_STATUS, v);
        chk("R7 late match write", {31'b0, v[0]}, {31'b0, exp_hit});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int m0, m1, s, k;
        void'($urandom(32'd2024));
        do_reset();

        // R1 reset state
        rd(A_CNT01, v);  chk("R1 pair count", v, 32'h0);
        rd(A_CNT2, v);   chk("R1 c2 count", v, 32'h0);
        rd(A_STATUS, v); chk("R1 status", v, 32'h0);
        rd(A_MATCH, v);  chk("R1 match", v, 32'hFFFF_FFFF);
        rd(A_CTRL, v);   chk("R1 ctrl", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R3, R2, R8: C0 match without clear, hold, resume, delayed reset
        m0 = $urandom_range(5, 40);
        wr(A_MATCH, {16'hFFFF, 16'(m0)});
        wr(A_CTRL, 32'h1);
        tick(m0 - 1);
        rd(A_CNT01, v);  chk("R2 c0 counting", v, 32'(m0 - 1));
        rd(A_STATUS, v); chk("R3 no event before match", v, 32'h0);
        tick(1);
        rd(A_STATUS, v); chk("R3 c0 event", v, 32'h1);
        tick(1);
        rd(A_CNT01, v);  chk("R3 c0 continues past match", v, 32'(m0 + 1));
        wr(A_CTRL, 32'h0);
        tick(4);
        rd(A_CNT01, v);  chk("R2 disabled hold", v, 32'(m0 + 2));
        wr(A_CTRL, 32'h1);
        tick(3);
        rd(A_CNT01, v);  chk("R2 resume", v, 32'(m0 + 5));
        wr(A_CTRL, 32'h0);
        wr(A_RESET, 32'h1);
        tick(2);
        rd(A_CNT01, v);  chk("R8 not yet cleared", v, 32'(m0 + 6));
        tick(1);
        rd(A_CNT01, v);  chk("R8 cleared on third edge", v, 32'h0);

        // R4, R12, R5: cascade with C0 clear-on-match
        do_reset();
        m0 = $urandom_range(3, 8);
        m1 = $urandom_range(2, 4);
        wr(A_MATCH, {16'(m1), 16'(m0)});
        wr(A_CTRL, 32'h33);
        tick(m0);
        rd(A_CNT01, v);  chk("R4 c1 waits one edge", v, 32'h0);
        tick(1);
        rd(A_CNT01, v);  chk("R12 R4 coherent pair", v, 32'h0001_0001);
        tick(m1 * m0 - m0 - 1);
        rd(A_STATUS, v); chk("R5 no c1 event yet", {31'b0, v[1]}, 32'h0);
        tick(1);
        rd(A_STATUS, v); chk("R5 c1 event", {31'b0, v[1]}, 32'h1);
        tick(m0);
        rd(A_CNT01, v);  chk("R5 c1 keeps counting", {16'b0, v[31:16]}, 32'(m1 + 1));

        // R4, R5, R10, R9: C1 alone with clear-on-match, then mask and clear
        do_reset();
        m1 = $urandom_range(5, 20);
        wr(A_MATCH, {16'(m1), 16'hFFFF});
        wr(A_CTRL, 32'h42);
        tick(m1 - 1);
        rd(A_CNT01, v);  chk("R4 c1 free count", {16'b0, v[31:16]}, 32'(m1 - 1));
        tick(1);
        rd(A_CNT01, v);  chk("R5 c1 clear on match", {16'b0, v[31:16]}, 32'h0);
        rd(A_STATUS, v); chk("R5 c1 status", v, 32'h2);
        chk("R10 masked irq low", {31'b0, irq}, 32'h0);
        wr(A_MASK, 32'h2);
        chk("R10 unmasked irq high", {31'b0, irq}, 32'h1);
        wr(A_MASK, 32'h1);
        chk("R10 other mask irq low", {31'b0, irq}, 32'h0);
        wr(A_STATUS, 32'h2);
        rd(A_STATUS, v); chk("R9 write one clears", v, 32'h0);

        // R6, R9: C2 rising and falling toggles
        do_reset();
        s = $urandom_range(2, 5);
        wr(A_TOGGLE, 32'(s));
        wr(A_CTRL, 32'h4);
        tick((1 << s) - 1);
        rd(A_CNT2, v);   chk("R6 c2 count", v, 32'((1 << s) - 1));
        rd(A_STATUS, v); chk("R6 no toggle yet", v, 32'h0);
        tick(1);
        rd(A_STATUS, v); chk("R6 rising toggle", v, 32'h4);
        wr(A_STATUS, 32'h4);
        rd(A_STATUS, v); chk("R9 c2 cleared", v, 32'h0);
        tick((1 << s) - 2);
        rd(A_STATUS, v); chk("R6 quiet between toggles", v, 32'h0);
        tick(1);
        rd(A_STATUS, v); chk("R6 falling toggle", v, 32'h4);

        // R7: match write latency
        run_lat(5, 1'b0);
        run_lat(6, 1'b1);

        // R11: lock
        do_reset();
        wr(A_LOCK, 32'h1);
        wr(A_CTRL, 32'h1);
        wr(A_MATCH, 32'h0005_0005);
        wr(A_TOGGLE, 32'h3);
        wr(A_MASK, 32'h5);
        tick(3);
        rd(A_CTRL, v);   chk("R11 ctrl locked", v, 32'h0);
        rd(A_MATCH, v);  chk("R11 match locked", v, 32'hFFFF_FFFF);
        rd(A_TOGGLE, v); chk("R11 toggle locked", v, 32'h0);
        rd(A_MASK, v);   chk("R11 mask allowed", v, 32'h5);
        rd(A_CNT01, v);  chk("R11 counter idle", v, 32'h0);
        wr(A_LOCK, 32'h0);
        wr(A_CTRL, 32'h1);
        rd(A_CTRL, v);   chk("R11 unlocked write", v, 32'h1);

        // Random: C0 modulo count and C2 together (R3, R6, R12)
        for (int it = 0; it < 8; it++) begin
            do_reset();
            m0 = $urandom_range(2, 40);
            k  = $urandom_range(1, 100);
            wr(A_MATCH, {16'hFFFF, 16'(m0)});
            wr(A_CTRL, 32'h25);
            tick(k);
            rd(A_CNT01, v);  chk("R3 random c0 modulo", v, exp_mod(k, m0));
            rd(A_CNT2, v);   chk("R12 random c2", v, 32'(k));
            rd(A_STATUS, v); chk("R6 R3 random status", v, {29'b0, 1'b1, 1'b0, (k >= m0)});
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule